// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This unit sits between the pads of a programmable logic array and its core. Two request pins and a configuration enable control it. When the feature is enabled and either request pin is high, the unit freezes the whole I/O picture. It stops the array's internal registers from advancing. It holds every pad output value and every pad output enable at what they were, so a pad that was high-impedance stays high-impedance. It also presents a frozen copy of the input pins to the array. No input transition reaches the array until both request pins are low again. With the feature enabled, the request pins are never visible to the array as logic inputs.

Each input pin has a keeper. While a pin is driven, the array sees the live level. Once the pin is left undriven, the array sees the last level that was driven. With the feature disabled, the unit is transparent and the request pins act as ordinary inputs.

Top module: `pd_hold_unit`

## Requirements
- R1: The first cycle in which power-down is active (`cfg_pd_en` high and `pd_req_a` or `pd_req_b` high) is the capture cycle. From the following cycle, `pad_out` and `pad_oe` equal the `core_out` and `core_oe` values present in the capture cycle. In the capture cycle itself, the pads still show live values.
- R2: Either request pin alone, with the other one low, starts and keeps power-down.
- R3: While the hold lasts, `pad_out` and `pad_oe` do not change, whatever the core drives. A `pad_oe` bit that was 0 (high-impedance) at capture stays 0.
- R4: While the hold lasts, `array_in` does not change, whatever the input pins or their drive status do.
- R5: `array_freeze` is 1 in exactly the cycles in which power-down is active, including the capture cycle, and is 0 otherwise.
- R6: Release takes effect one cycle after power-down goes inactive. In that first inactive cycle the held values still show. From the next cycle on, the pads and `array_in` follow their live sources again.
- R7: With `cfg_pd_en` = 1, `array_pd_a` and `array_pd_b` read 0. With `cfg_pd_en` = 0, they mirror `pd_req_a` and `pd_req_b`.
- R8: With `cfg_pd_en` = 0, the request pins start no hold. The pads equal the core values, `array_in` equals the kept pin levels, and `array_freeze` is 0. If the enable drops during a hold, the hold ends as in R6.
- R9: Keeper behaviour, bit for bit:
  - a pin with `pin_drv` = 1 shows `pin_in` on `array_in` in the same cycle;
  - a pin with `pin_drv` = 0 shows the level it had at the last clock edge at which it was driven.
- R10: Synchronous active-low reset clears the hold and every keeper level. After reset, undriven pins read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_pd_en | input | 1 | Enables pin-controlled power-down |
| pd_req_a | input | 1 | First power-down request pin |
| pd_req_b | input | 1 | Second power-down request pin |
| pin_in | input | N_IN | Input pin levels |
| pin_drv | input | N_IN | 1 where the input pin is actively driven |
| core_out | input | N_OUT | Output data from the array |
| core_oe | input | N_OUT | Output enables from the array |
| array_in | output | N_IN | Input values presented to the array |
| array_pd_a | output | 1 | First request pin as an array input |
| array_pd_b | output | 1 | Second request pin as an array input |
| array_freeze | output | 1 | Holds the array's internal registers |
| pad_out | output | N_OUT | Output data to the pads |
| pad_oe | output | N_OUT | Output enables to the pads |

## Verification
The hold is tried three ways: started by the first pin alone, started by the second pin alone, and kept going with both pins high. These runs show that each pin triggers on its own and that overlap does not restart the capture. During the hold, core values and pin levels change every cycle, with enables both set and cleared. A stale or re-captured value, or a high-impedance pad that becomes driven, therefore shows up at once. Release is sampled in the last held cycle and again in the first live cycle, which separates one-cycle release from early or late release. The keeper is exercised with all pins driven, no pins driven and a half-driven mix, and the enable is also dropped in the middle of a hold.

// File: rtl/pdh_pkg.sv
// Package: shared types for the power-down hold unit.
// Assumes: nothing beyond a single clock domain.
package pdh_pkg;

    // Hold state of the unit
    typedef enum logic {
        PDH_RUN    = 1'b0,
        PDH_FROZEN = 1'b1
    } pdh_state_e;

endpackage

// File: rtl/pdh_request_detect.sv
// Module: pdh_request_detect
// Combines the enable and the two request pins into an active flag, and keeps
// the hold state that lags that flag by one cycle.
// Assumes: the request pins are already synchronous to clk.
module pdh_request_detect
    import pdh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic req_a,
    input  logic req_b,
    output logic pd_now,
    output logic held,
    output logic capture
);

    pdh_state_e state_q;

    // Power-down is requested now
    always_comb pd_now = cfg_en & (req_a | req_b);

    // Hold state follows the request one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= PDH_RUN;
        else if (pd_now) state_q <= PDH_FROZEN;
        else             state_q <= PDH_RUN;
    end

    // Expose the state and the first-seen pulse
    always_comb begin
        held    = (state_q == PDH_FROZEN);
        capture = pd_now & ~held;
    end

endmodule

// File: rtl/pdh_pin_keeper.sv
// Module: pdh_pin_keeper
// Per-pin keeper: a driven pin passes through; an undriven pin shows the
// level it had at the last clock edge at which it was driven.
// Assumes: pin_drv marks each pin that is actively driven.
module pdh_pin_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] pin_drv,
    output logic [W-1:0] kept
);

    for (genvar i = 0; i < W; i++) begin : g_keep
        logic level_q;

        // Remember the last driven level of this pin
        always_ff @(posedge clk) begin
            if (!rst_n)          level_q <= 1'b0;
            else if (pin_drv[i]) level_q <= pin_in[i];
        end

        // Pass the live level while driven, the kept level otherwise
        always_comb kept[i] = pin_drv[i] ? pin_in[i] : level_q;
    end

endmodule

// File: rtl/pdh_snapshot.sv
// Module: pdh_snapshot
// Snapshot register with a bypass mux: it captures the live vector on the
// capture pulse and shows the stored copy while the hold is set.
// Assumes: capture and hold come from pdh_request_detect.
module pdh_snapshot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         hold,
    input  logic [W-1:0] live,
    output logic [W-1:0] shown
);

    logic [W-1:0] snap_q;

    // Take the copy in the cycle in which power-down is first seen
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (capture) snap_q <= live;
    end

    // Show the frozen copy during the hold
    always_comb shown = hold ? snap_q : live;

endmodule

// File: rtl/pd_hold_unit.sv
// Module: pd_hold_unit (top)
// Freezes the I/O state of a logic array while pin-controlled power-down is
// active: output data, output enables and array inputs are held, and the
// array is told to stop its registers.
// Assumes: every input is synchronous to clk; the array honours array_freeze
// as a clock enable for its internal state.
module pd_hold_unit #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_pd_en,
    input  logic             pd_req_a,
    input  logic             pd_req_b,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_IN-1:0]  pin_drv,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_IN-1:0]  array_in,
    output logic             array_pd_a,
    output logic             array_pd_b,
    output logic             array_freeze,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe
);

    localparam int OUT_W = 2 * N_OUT;

    logic            pd_now;
    logic            held;
    logic            capture;
    logic [N_IN-1:0] kept;
    logic [OUT_W-1:0] out_shown;

    pdh_request_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_pd_en),
        .req_a   (pd_req_a),
        .req_b   (pd_req_b),
        .pd_now  (pd_now),
        .held    (held),
        .capture (capture)
    );

    pdh_pin_keeper #(.W(N_IN)) u_keeper (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .pin_drv (pin_drv),
        .kept    (kept)
    );

    pdh_snapshot #(.W(N_IN)) u_in_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .hold    (held),
        .live    (kept),
        .shown   (array_in)
    );

    pdh_snapshot #(.W(OUT_W)) u_out_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .hold    (held),
        .live    ({core_oe, core_out}),
        .shown   (out_shown)
    );

    // Split the held output vector and gate the request pins
    always_comb begin
        pad_out      = out_shown[N_OUT-1:0];
        pad_oe       = out_shown[OUT_W-1:N_OUT];
        array_freeze = pd_now;
        array_pd_a   = pd_req_a & ~cfg_pd_en;
        array_pd_b   = pd_req_b & ~cfg_pd_en;
    end

endmodule

// File: rtl/pd_hold_unit_chk.sv
// Module: pd_hold_unit_chk
// Checks the hold and release timing of pd_hold_unit at its ports.
// Assumes: it is bound to every instance of pd_hold_unit.
module pd_hold_unit_chk #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_pd_en,
    input logic             pd_req_a,
    input logic             pd_req_b,
    input logic [N_IN-1:0]  array_in,
    input logic [N_OUT-1:0] core_out,
    input logic [N_OUT-1:0] core_oe,
    input logic [N_OUT-1:0] pad_out,
    input logic [N_OUT-1:0] pad_oe
);

    logic act;
    logic act_prev;

    // Request as seen at the ports
    always_comb act = cfg_pd_en & (pd_req_a | pd_req_b);

    // Track the request of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) act_prev <= 1'b0;
        else        act_prev <= act;
    end

    // R1
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !act_prev) |=> (pad_out == $past(core_out) && pad_oe == $past(core_oe)));

    // R3
    pads_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && act_prev) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R4
    inputs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && act_prev) |=> $stable(array_in));

    // R6
    release_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (pad_out == core_out && pad_oe == core_oe));

    // R8
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pd_en && !act_prev) |-> (pad_out == core_out && pad_oe == core_oe));

endmodule

bind pd_hold_unit pd_hold_unit_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pd_en (cfg_pd_en),
    .pd_req_a  (pd_req_a),
    .pd_req_b  (pd_req_b),
    .array_in  (array_in),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/tb_pd_hold_unit.sv
module tb_pd_hold_unit;

    localparam int NI = 8;
    localparam int NO = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_pd_en = 1'b0, pd_req_a = 1'b0, pd_req_b = 1'b0;
    logic [NI-1:0] pin_in = '0, pin_drv = '0;
    logic [NO-1:0] core_out = '0, core_oe = '0;
    logic [NI-1:0] array_in;
    logic          array_pd_a, array_pd_b, array_freeze;
    logic [NO-1:0] pad_out, pad_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pd_hold_unit #(.N_IN(NI), .N_OUT(NO)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en),
        .pd_req_a(pd_req_a), .pd_req_b(pd_req_b),
        .pin_in(pin_in), .pin_drv(pin_drv),
        .core_out(core_out), .core_oe(core_oe),
        .array_in(array_in), .array_pd_a(array_pd_a), .array_pd_b(array_pd_b),
        .array_freeze(array_freeze), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct {
        logic [NO-1:0] pout;
        logic [NO-1:0] poe;
        logic [NI-1:0] ain;
        logic          frz;
        logic          pa;
        logic          pb;
        string         tag;
    } exp_t;

    exp_t scb[$];
    event pushed;

    // Reference state taken from the requirements
    logic          m_hold = 1'b0;
    logic [NO-1:0] m_sout = '0, m_soe = '0;
    logic [NI-1:0] m_sin = '0, m_keep = '0;

    task automatic step(input logic en, input logic a, input logic b,
                        input logic [NI-1:0] pin, input logic [NI-1:0] drv,
                        input logic [NO-1:0] cout, input logic [NO-1:0] coe,
                        input string tag);
        exp_t e;
        logic pd;
        logic [NI-1:0] kept;
        @(negedge clk);
        cfg_pd_en = en; pd_req_a = a; pd_req_b = b;
        pin_in = pin; pin_drv = drv; core_out = cout; core_oe = coe;
        pd   = en & (a | b);
        kept = (drv & pin) | (~drv & m_keep);
        e.pout = m_hold ? m_sout : cout;
        e.poe  = m_hold ? m_soe  : coe;
        e.ain  = m_hold ? m_sin  : kept;
        e.frz  = pd;
        e.pa   = en ? 1'b0 : a;
        e.pb   = en ? 1'b0 : b;
        e.tag  = tag;
        scb.push_back(e);
        -> pushed;
        if (pd && !m_hold) begin
            m_sout = cout; m_soe = coe; m_sin = kept;
        end
        m_keep = kept;
        m_hold = pd;
    endtask

    // Monitor: pop the expected item and compare with the ports
    initial begin
        forever begin
            exp_t e;
            @(pushed);
            #1;
            e = scb.pop_front();
            checks++;
            if ({pad_out, pad_oe, array_in, array_freeze, array_pd_a, array_pd_b} !==
                {e.pout, e.poe, e.ain, e.frz, e.pa, e.pb}) begin
                errors++;
                $display("FAIL %s: got out=%h oe=%h in=%h frz=%b pa=%b pb=%b, expected out=%h oe=%h in=%h frz=%b pa=%b pb=%b",
                         e.tag, pad_out, pad_oe, array_in, array_freeze, array_pd_a, array_pd_b,
                         e.pout, e.poe, e.ain, e.frz, e.pa, e.pb);
            end
        end
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R10 reset state");
        step(0, 0, 0, 8'hA5, 8'hFF, 8'h3C, 8'hF0, "R8 transparent");
        step(0, 1, 0, 8'h5A, 8'hFF, 8'hC3, 8'h0F, "R8 R7 pin a ignored when disabled");
        step(0, 1, 1, 8'h5A, 8'hFF, 8'h12, 8'h34, "R7 both pins mirrored");
        step(0, 0, 0, 8'h96, 8'hFF, 8'h00, 8'h00, "R9 driven");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R9 undriven keeps");
        step(0, 0, 0, 8'hFF, 8'h0F, 8'h00, 8'h00, "R9 half driven");
        step(1, 0, 0, 8'h3C, 8'hFF, 8'h11, 8'h0F, "R6 enabled idle");
        step(1, 1, 0, 8'h3C, 8'hFF, 8'h22, 8'h33, "R5 R1 capture cycle");
        step(1, 1, 0, 8'hC3, 8'hFF, 8'h44, 8'hFF, "R1 R3 held pads");
        step(1, 1, 1, 8'h00, 8'h00, 8'h55, 8'h00, "R4 inputs held");
        step(1, 0, 0, 8'h81, 8'hFF, 8'h66, 8'h0F, "R6 last held cycle");
        step(1, 0, 0, 8'h81, 8'hFF, 8'h66, 8'h0F, "R6 released");
        step(1, 0, 1, 8'h7E, 8'hFF, 8'h77, 8'h00, "R2 pin b capture");
        step(1, 0, 1, 8'h18, 8'hFF, 8'h88, 8'hFF, "R2 R3 high impedance held");
        step(0, 0, 1, 8'h24, 8'hFF, 8'h99, 8'hAA, "R8 enable dropped");
        step(0, 0, 1, 8'h24, 8'hFF, 8'h99, 8'hAA, "R8 released after drop");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule